// File: doc/BRIEF.md
# Operator Panel Console Controller

This block sits between an operator panel and a 16-bit processor. The panel has sixteen data switches, sixteen indicator lamps, a 4-bit register selector, a mode selector, a target selector and a Start pushbutton. The block turns each Start press into a single console command. That command can write the switch word into a register, the status word or memory. It can step the address held in the program counter. It can also ask the processor core for one instruction or for free running.

The block has no separate console address register. Memory is always accessed at the address held in register 0, the program counter. Each memory access made from the panel advances that register by one 16-bit word, which is two byte addresses. To examine memory, the operator loads a start address into register 0, selects the memory target and presses Start repeatedly. On the panel side, bit 0 of the switches and of the lamps is the most significant bit of the machine word.

Top module: `panel_console`

## Requirements
- R1: Panel bit 0 of `sw_data` and `lamp` is the most significant bit (bit 15) of the machine word. A switch pattern with only panel bit 0 set is written as 16'h8000.
- R2: In Load mode (`mode_sel`=0) with the register target (`tgt_sel`=0), a Start press writes the switch word into the register selected by `reg_sel`.
- R3: In Load mode with the status target (`tgt_sel`=1), a Start press writes the switch word into the status register.
- R4: In Load mode with the memory target (`tgt_sel`=2), a Start press writes the switch word to memory at the address in register 0. In the same cycle, register 0 is written with its old value plus 2.
- R5: In Read mode (`mode_sel`=1) with the memory target, a Start press advances register 0 by 2 and writes nothing to memory.
- R6: In Read mode the lamps show, from the next clock on, the register selected by `reg_sel`, the status word, or the memory word at the register 0 address, according to the target.
- R7: In any mode other than Read, the lamps show the switch word.
- R8: `start_raw` passes through a two-stage synchroniser and an edge detector. Each press gives exactly one command, however long the button is held. In Step mode (`mode_sel`=2), each press raises `cpu_step` for exactly one cycle.
- R9: In Run mode (`mode_sel`=3), a Start press sets `cpu_run`. It stays set until a Start press in another mode, and that press does nothing but clear it.
- R10: While `cpu_run` is set, no write to registers, status or memory is issued and no step is requested.
- R11: The unused mode codes (4 to 7) and the unused target code (3) make a Start press write nothing.
- R12: After reset, the lamps read 0, `cpu_run` and `cpu_step` are low and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_data | input | 16 | Data switches, index 0 is the MSB |
| lamp | output | 16 | Indicator lamps, index 0 is the MSB |
| reg_sel | input | 4 | Register selector |
| mode_sel | input | 3 | 0 Load, 1 Read, 2 Step, 3 Run, others unused |
| tgt_sel | input | 2 | 0 register, 1 status, 2 memory, 3 unused |
| start_raw | input | 1 | Debounced Start button level, asynchronous |
| rf_raddr | output | 4 | Register file read address (follows `reg_sel`) |
| rf_rdata | input | 16 | Register file read data, combinational |
| pc_rdata | input | 16 | Current value of register 0 |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 16 | Register file write data |
| st_rdata | input | 16 | Status register value |
| st_we | output | 1 | Status write strobe |
| st_wdata | output | 16 | Status write data |
| mem_addr | output | 16 | Memory byte address (register 0) |
| mem_rdata | input | 16 | Memory read data, combinational |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| cpu_step | output | 1 | One-cycle request to execute a single instruction |
| cpu_run | output | 1 | Continuous execution request |

## Verification
A rise on `start_raw` goes through two synchroniser stages and an edge register. The resulting write strobes act on the third rising edge after the rise, and `cpu_step` is high for the cycle after that. The bench holds Start for four cycles and releases it for four more before it inspects its own register and memory models, so every write has already landed. The lamp register follows its selection one edge later. After a mode, target or program-counter change, the bench waits two full cycles and samples on the falling edge.

// File: rtl/console_pkg.sv
package console_pkg;
  parameter int unsigned CON_DW      = 16;
  parameter int unsigned CON_RW      = 4;
  parameter int unsigned CON_PC_STEP = 2;

  typedef enum logic [2:0] {
    MODE_LOAD = 3'd0,
    MODE_READ = 3'd1,
    MODE_STEP = 3'd2,
    MODE_RUN  = 3'd3
  } mode_e;

  typedef enum logic [1:0] {
    TGT_REG  = 2'd0,
    TGT_STAT = 2'd1,
    TGT_MEM  = 2'd2
  } tgt_e;

  // Next console address after one word access.
  function automatic logic [CON_DW-1:0] pc_advance(input logic [CON_DW-1:0] pc);
    return pc + CON_DW'(CON_PC_STEP);
  endfunction
endpackage

// File: rtl/console_start_sync.sv
module console_start_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_raw,
  output logic start_pulse
);
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], start_raw};
  end

  // Rising edge of the synchronised level.
  assign start_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/console_seq.sv
module console_seq
  import console_pkg::*;
#(
  parameter int unsigned DW = CON_DW,
  parameter int unsigned RW = CON_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_pulse,
  input  logic [2:0]    mode_sel,
  input  logic [1:0]    tgt_sel,
  input  logic [RW-1:0] reg_sel,
  input  logic [DW-1:0] sw_word,
  input  logic [DW-1:0] pc_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          st_we,
  output logic          mem_we,
  output logic          cpu_step,
  output logic          cpu_run
);
  logic  step_d, run_d;
  mode_e mode;
  tgt_e  tgt;

  assign mode = mode_e'(mode_sel);
  assign tgt  = tgt_e'(tgt_sel);

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = reg_sel;
    rf_wdata = sw_word;
    st_we    = 1'b0;
    mem_we   = 1'b0;
    step_d   = 1'b0;
    run_d    = cpu_run;
    if (start_pulse) begin
      if (cpu_run) begin
        if (mode != MODE_RUN) run_d = 1'b0;
      end else begin
        case (mode)
          MODE_LOAD: begin
            case (tgt)
              TGT_REG:  rf_we = 1'b1;
              TGT_STAT: st_we = 1'b1;
              TGT_MEM: begin
                mem_we   = 1'b1;
                rf_we    = 1'b1;
                rf_waddr = '0;
                rf_wdata = pc_advance(pc_rdata);
              end
              default: ;
            endcase
          end
          MODE_READ: begin
            if (tgt == TGT_MEM) begin
              rf_we    = 1'b1;
              rf_waddr = '0;
              rf_wdata = pc_advance(pc_rdata);
            end
          end
          MODE_STEP: step_d = 1'b1;
          MODE_RUN:  run_d  = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_step <= 1'b0;
      cpu_run  <= 1'b0;
    end else begin
      cpu_step <= step_d;
      cpu_run  <= run_d;
    end
  end
endmodule

// File: rtl/console_lamp.sv
module console_lamp
  import console_pkg::*;
#(
  parameter int unsigned DW = CON_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic [1:0]    tgt_sel,
  input  logic [DW-1:0] sw_word,
  input  logic [DW-1:0] rf_rdata,
  input  logic [DW-1:0] st_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] lamp_word
);
  logic [DW-1:0] lamp_d;

  always_comb begin
    if (mode_e'(mode_sel) == MODE_READ) begin
      case (tgt_e'(tgt_sel))
        TGT_REG:  lamp_d = rf_rdata;
        TGT_STAT: lamp_d = st_rdata;
        TGT_MEM:  lamp_d = mem_rdata;
        default:  lamp_d = '0;
      endcase
    end else begin
      lamp_d = sw_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lamp_word <= '0;
    else        lamp_word <= lamp_d;
  end
endmodule

// File: rtl/panel_console.sv
module panel_console
  import console_pkg::*;
#(
  parameter int unsigned DW          = CON_DW,
  parameter int unsigned RW          = CON_RW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [0:DW-1] sw_data,
  output logic [0:DW-1] lamp,
  input  logic [RW-1:0] reg_sel,
  input  logic [2:0]    mode_sel,
  input  logic [1:0]    tgt_sel,
  input  logic          start_raw,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  input  logic [DW-1:0] pc_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] st_rdata,
  output logic          st_we,
  output logic [DW-1:0] st_wdata,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          cpu_step,
  output logic          cpu_run
);
  logic [DW-1:0] sw_word;
  logic [DW-1:0] lamp_word;
  logic          start_pulse;

  // Panel index i carries machine bit DW-1-i.
  for (genvar i = 0; i < DW; i++) begin : g_bitmap
    assign sw_word[DW-1-i] = sw_data[i];
    assign lamp[i]         = lamp_word[DW-1-i];
  end

  assign rf_raddr  = reg_sel;
  assign mem_addr  = pc_rdata;
  assign st_wdata  = sw_word;
  assign mem_wdata = sw_word;

  console_start_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .start_raw(start_raw), .start_pulse(start_pulse)
  );

  console_seq #(.DW(DW), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
    .mode_sel(mode_sel), .tgt_sel(tgt_sel), .reg_sel(reg_sel),
    .sw_word(sw_word), .pc_rdata(pc_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_we(st_we), .mem_we(mem_we),
    .cpu_step(cpu_step), .cpu_run(cpu_run)
  );

  console_lamp #(.DW(DW)) u_lamp (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tgt_sel(tgt_sel),
    .sw_word(sw_word), .rf_rdata(rf_rdata), .st_rdata(st_rdata),
    .mem_rdata(mem_rdata), .lamp_word(lamp_word)
  );
endmodule

// File: rtl/panel_console_chk.sv
module panel_console_chk
  import console_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_pulse,
  input logic [2:0]        mode_sel,
  input logic              rf_we,
  input logic [CON_RW-1:0] rf_waddr,
  input logic [CON_DW-1:0] rf_wdata,
  input logic [CON_DW-1:0] pc_rdata,
  input logic              st_we,
  input logic              mem_we,
  input logic              cpu_step,
  input logic              cpu_run
);
  a_r8_one_pulse_per_press: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r8_step_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_step |=> !cpu_step);

  a_r8_step_after_press: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_step |-> ($past(start_pulse) && $past(mode_sel) == 3'd2));

  a_r4_pc_moves_with_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (rf_we && rf_waddr == '0 && rf_wdata == pc_rdata + 16'd2));

  a_r10_no_write_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || st_we || mem_we) |-> !cpu_run);

  a_r9_run_starts_on_press: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> ($past(start_pulse) && $past(mode_sel) == 3'd3));
endmodule

bind panel_console panel_console_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .mode_sel(mode_sel),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_rdata(pc_rdata),
  .st_we(st_we), .mem_we(mem_we), .cpu_step(cpu_step), .cpu_run(cpu_run)
);

// File: tb/panel_console_tb.sv
module panel_console_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:15] sw_data = '0;
  logic [0:15] lamp;
  logic [3:0]  reg_sel = '0;
  logic [2:0]  mode_sel = 3'd1;
  logic [1:0]  tgt_sel = '0;
  logic        start_raw = 1'b0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, pc_rdata, rf_wdata, st_wdata, mem_addr, mem_rdata, mem_wdata;
  logic        rf_we, st_we, mem_we, cpu_step, cpu_run;

  logic [15:0] rf_m [16];
  logic [15:0] st_m;
  logic [15:0] mem_m [128];
  int n_chk = 0, n_fail = 0, n_step = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata  = rf_m[rf_raddr];
  assign pc_rdata  = rf_m[0];
  assign mem_rdata = mem_m[mem_addr[7:1]];

  always @(posedge clk) begin
    if (rf_we)  rf_m[rf_waddr] <= rf_wdata;
    if (st_we)  st_m <= st_wdata;
    if (mem_we) mem_m[mem_addr[7:1]] <= mem_wdata;
    if (cpu_step) n_step <= n_step + 1;
  end

  panel_console u_dut (
    .clk(clk), .rst_n(rst_n), .sw_data(sw_data), .lamp(lamp), .reg_sel(reg_sel),
    .mode_sel(mode_sel), .tgt_sel(tgt_sel), .start_raw(start_raw),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .pc_rdata(pc_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_rdata(st_m), .st_we(st_we), .st_wdata(st_wdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .cpu_step(cpu_step), .cpu_run(cpu_run)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic press();
    @(negedge clk); start_raw = 1'b1;
    repeat (4) @(negedge clk);
    start_raw = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] m, input logic [1:0] t, input logic [3:0] r,
                       input logic [15:0] s);
    @(negedge clk);
    mode_sel = m; tgt_sel = t; reg_sel = r; sw_data = s;
  endtask

  // target, register, switch word, expected word
  typedef struct packed { logic [1:0] tgt; logic [3:0] rs; logic [15:0] sw; logic [15:0] exp; } vec_t;
  localparam vec_t VECS [5] = '{
    '{2'd0, 4'd3,  16'h1234, 16'h1234},
    '{2'd0, 4'd15, 16'hBEEF, 16'hBEEF},
    '{2'd1, 4'd0,  16'h00A5, 16'h00A5},
    '{2'd0, 4'd7,  16'h8001, 16'h8001},
    '{2'd0, 4'd1,  16'hFFFF, 16'hFFFF}
  };

  initial begin
    for (int i = 0; i < 16; i++) rf_m[i] = '0;
    for (int i = 0; i < 128; i++) mem_m[i] = '0;
    st_m = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 lamp", lamp, 16'h0);
    check("R12 run", {15'd0, cpu_run}, 16'd0);
    check("R12 strobes", {13'd0, rf_we, st_we, mem_we}, 16'd0);
    rst_n = 1'b1;
    settle();

    // R2/R3 load then R6 read back through the lamps
    for (int i = 0; i < 5; i++) begin
      setup(3'd0, VECS[i].tgt, VECS[i].rs, VECS[i].sw);
      press();
      if (VECS[i].tgt == 2'd1) check("R3 status load", st_m, VECS[i].exp);
      else                     check("R2 register load", rf_m[VECS[i].rs], VECS[i].exp);
      setup(3'd1, VECS[i].tgt, VECS[i].rs, 16'h0);
      settle();
      check("R6 lamp read", lamp, VECS[i].exp);
    end

    // R1 panel bit 0 is the MSB
    setup(3'd0, 2'd0, 4'd2, 16'h0);
    sw_data[0] = 1'b1;
    press();
    check("R1 switch bit 0", rf_m[2], 16'h8000);
    setup(3'd1, 2'd0, 4'd2, 16'h0);
    settle();
    check("R1 lamp bit 0", {15'd0, lamp[0]}, 16'd1);

    // R4 memory load at PC with PC advance
    setup(3'd0, 2'd0, 4'd0, 16'h0010);
    press();
    setup(3'd0, 2'd2, 4'd0, 16'hCAFE);
    press();
    check("R4 mem write", mem_m[8], 16'hCAFE);
    check("R4 pc advance", rf_m[0], 16'h0012);
    setup(3'd0, 2'd2, 4'd0, 16'h0BAD);
    press();
    check("R4 second mem write", mem_m[9], 16'h0BAD);
    check("R4 second pc advance", rf_m[0], 16'h0014);

    // R5/R6 read memory stepping
    setup(3'd0, 2'd0, 4'd0, 16'h0010);
    press();
    setup(3'd1, 2'd2, 4'd0, 16'h0);
    settle();
    check("R6 lamp mem", lamp, 16'hCAFE);
    press();
    check("R5 pc advance", rf_m[0], 16'h0012);
    check("R5 mem untouched", mem_m[8], 16'hCAFE);
    check("R6 lamp next word", lamp, 16'h0BAD);

    // R7 lamps echo switches outside Read
    setup(3'd0, 2'd0, 4'd0, 16'h5A5A);
    settle();
    check("R7 lamp echo", lamp, 16'h5A5A);

    // R8 one step per press
    setup(3'd2, 2'd0, 4'd0, 16'h0);
    press();
    check("R8 one step", n_step[15:0], 16'd1);
    press();
    check("R8 second step", n_step[15:0], 16'd2);

    // R9/R10 run, then stop press writes nothing
    setup(3'd3, 2'd0, 4'd0, 16'h0);
    press();
    check("R9 run set", {15'd0, cpu_run}, 16'd1);
    setup(3'd2, 2'd0, 4'd0, 16'h0);
    setup(3'd0, 2'd0, 4'd4, 16'h7777);
    press();
    check("R10 write ignored", rf_m[4], 16'h0);
    check("R9 run cleared", {15'd0, cpu_run}, 16'd0);
    check("R10 no step", n_step[15:0], 16'd2);
    press();
    check("R10 write after stop", rf_m[4], 16'h7777);

    // R11 unused codes
    setup(3'd4, 2'd0, 4'd5, 16'h1111);
    press();
    check("R11 unused mode", rf_m[5], 16'h0);
    setup(3'd0, 2'd3, 4'd5, 16'h2222);
    press();
    check("R11 unused target reg", rf_m[5], 16'h0);
    check("R11 unused target pc", rf_m[0], 16'h0012);
    check("R11 unused target status", st_m, 16'h00A5);

    // R12 reset while running
    setup(3'd3, 2'd0, 4'd0, 16'h0);
    press();
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 run after reset", {15'd0, cpu_run}, 16'd0);
    check("R12 lamp after reset", lamp, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule